// File: doc/BRIEF.md
# Prioritised Interrupt Controller with Non-Maskable Input

This block gathers 32 maskable interrupt request lines and one active-low non-maskable pin. It presents a single request to a processor, together with the number of the winning vector. Each maskable line sets a pending latch. A software-written enable word decides which pending sources may be presented. A fixed linear resolver picks the winner: the highest-numbered source that is both pending and enabled.

The non-maskable pin passes through a two-stage synchroniser and an edge detector that reacts to its falling edge. Once latched, that request outranks every maskable source and ignores the enable word. The processor takes the presented vector by pulsing an acknowledge input. This clears the pending latch of exactly the vector on display. The request output then drops for one cycle, and the next winner appears in the following cycle.

Top module: `prio_intc`

## Requirements
- R1: While reset is held and in the first cycle after it, `irq_o` is 0 and `vec_o` is 0. Reset clears every pending latch and the enable word (all sources disabled).
- R2: A maskable line that is high at a clock edge sets its pending latch. The latch stays set after the line falls. With the source enabled, `irq_o`/`vec_o` show it on the second edge after the line is driven.
- R3: A pending source whose enable bit is 0 is never presented, and it keeps its latch. A write to the enable word (`en_we_i`=1 loads `en_wdata_i`, bit n enabling source n) takes effect on the edge after the write, and the output follows one edge later.
- R4: Among enabled pending maskable sources, the highest index wins and `vec_o` equals that index (0 to 31).
- R5: A falling edge on `nmi_n_i` latches a non-maskable request, which is presented as `vec_o`=32 on the fourth edge after the pin falls. A pin held low does not re-trigger after acknowledge, and a rising edge latches nothing.
- R6: A latched non-maskable request outranks every maskable source and is presented even when the enable word is all zeros.
- R7: When `irq_o` is 1, `vec_o` lies in 0..32. When `irq_o` is 0, `vec_o` is 0.
- R8: An acknowledge (`ack_i`=1 while `irq_o`=1) clears only the pending latch of the vector shown. `irq_o` is 0 on the next edge, and the next winner appears on the edge after that.
- R9: A request on the acknowledged source that arrives in the acknowledge cycle stays pending and is presented again.
- R10: `ack_i` asserted while `irq_o` is 0 has no effect on any pending latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_req_i | input | 32 | Maskable request lines, one per source |
| en_we_i | input | 1 | Write strobe for the enable word |
| en_wdata_i | input | 32 | New enable word |
| nmi_n_i | input | 1 | Non-maskable request pin, asynchronous, active on falling edge |
| ack_i | input | 1 | Processor takes the presented vector |
| irq_o | output | 1 | Registered interrupt request to the processor |
| vec_o | output | 6 | Registered vector number, 0..31 maskable, 32 non-maskable |

## Verification
Some rules are checked by the assertions on every cycle:
- the vector range and its zero value while idle;
- the one-cycle drop after an acknowledge;
- a presented maskable vector was enabled and had no enabled pending source above it;
- no maskable vector is shown while a non-maskable request was latched.

Other behaviour only the bench scenarios can show: the exact latencies through the synchroniser and the pending latches, latches surviving a mask, edge detection that does not re-trigger on a held-low pin, a request that collides with its own acknowledge, and an acknowledge with no request present being ignored.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
  localparam int DEF_NUM_SRC   = 32;
  localparam int DEF_SYNC_LEN  = 2;

  function automatic int vec_width(input int n);
    return $clog2(n + 1);
  endfunction

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/prio_intc_nmi_edge.sv
module prio_intc_nmi_edge #(
  parameter int SYNC_LEN = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  output logic fall_pulse
);
  logic [SYNC_LEN-1:0] chain_q;
  logic                last_q;

  genvar g;
  generate
    for (g = 0; g < SYNC_LEN; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b1;
          else     chain_q[g] <= pin_n;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b1;
          else     chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b1;
    else     last_q <= chain_q[SYNC_LEN-1];
  end

  assign fall_pulse = last_q & ~chain_q[SYNC_LEN-1];
endmodule

// File: rtl/prio_intc_latch.sv
module prio_intc_latch #(
  parameter int NUM_SRC = 32,
  parameter int VEC_W   = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] req,
  input  logic               en_we,
  input  logic [NUM_SRC-1:0] en_wdata,
  input  logic               nmi_fall,
  input  logic               clr_valid,
  input  logic [VEC_W-1:0]   clr_vec,
  output logic [NUM_SRC-1:0] en_q,
  output logic [NUM_SRC-1:0] pend_q,
  output logic               nmi_q
);
  localparam logic [VEC_W-1:0] NMI_VEC = VEC_W'(NUM_SRC);

  logic [NUM_SRC-1:0] clr_mask;
  logic               clr_nmi;

  always_comb begin
    clr_mask = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (clr_valid && clr_vec == VEC_W'(i)) clr_mask[i] = 1'b1;
    end
  end

  assign clr_nmi = clr_valid && (clr_vec == NMI_VEC);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      pend_q <= '0;
      nmi_q  <= 1'b0;
    end else begin
      if (en_we) en_q <= en_wdata;
      pend_q <= (pend_q & ~clr_mask) | req;
      nmi_q  <= (nmi_q & ~clr_nmi) | nmi_fall;
    end
  end
endmodule

// File: rtl/prio_intc_resolve.sv
module prio_intc_resolve #(
  parameter int NUM_SRC = 32,
  parameter int VEC_W   = 6
) (
  input  logic [NUM_SRC-1:0] cand,
  input  logic               nmi,
  output logic               hit,
  output logic [VEC_W-1:0]   win
);
  localparam logic [VEC_W-1:0] NMI_VEC = VEC_W'(NUM_SRC);

  always_comb begin
    hit = 1'b0;
    win = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (cand[i]) begin
        hit = 1'b1;
        win = VEC_W'(i);
      end
    end
    if (nmi) begin
      hit = 1'b1;
      win = NMI_VEC;
    end
  end
endmodule

// File: rtl/prio_intc.sv
module prio_intc #(
  parameter int NUM_SRC  = prio_intc_pkg::DEF_NUM_SRC,
  parameter int SYNC_LEN = prio_intc_pkg::DEF_SYNC_LEN,
  localparam int VEC_W   = prio_intc_pkg::vec_width(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_req_i,
  input  logic               en_we_i,
  input  logic [NUM_SRC-1:0] en_wdata_i,
  input  logic               nmi_n_i,
  input  logic               ack_i,
  output logic               irq_o,
  output logic [VEC_W-1:0]   vec_o
);
  logic               nmi_fall;
  logic [NUM_SRC-1:0] en_q;
  logic [NUM_SRC-1:0] pend_q;
  logic               nmi_pend_q;
  logic               take;
  logic               hit;
  logic [VEC_W-1:0]   win;
  logic               irq_q;
  logic [VEC_W-1:0]   vec_q;

  assign take = ack_i & irq_q;

  prio_intc_nmi_edge #(.SYNC_LEN(SYNC_LEN)) u_nmi (
    .clk        (clk),
    .rst        (rst),
    .pin_n      (nmi_n_i),
    .fall_pulse (nmi_fall)
  );

  prio_intc_latch #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_latch (
    .clk       (clk),
    .rst       (rst),
    .req       (irq_req_i),
    .en_we     (en_we_i),
    .en_wdata  (en_wdata_i),
    .nmi_fall  (nmi_fall),
    .clr_valid (take),
    .clr_vec   (vec_q),
    .en_q      (en_q),
    .pend_q    (pend_q),
    .nmi_q     (nmi_pend_q)
  );

  prio_intc_resolve #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_res (
    .cand (pend_q & en_q),
    .nmi  (nmi_pend_q),
    .hit  (hit),
    .win  (win)
  );

  always_ff @(posedge clk) begin
    if (rst || take) begin
      irq_q <= 1'b0;
      vec_q <= '0;
    end else begin
      irq_q <= hit;
      vec_q <= hit ? win : '0;
    end
  end

  assign irq_o = irq_q;
  assign vec_o = vec_q;
endmodule

// File: rtl/prio_intc_checker.sv
module prio_intc_checker #(
  parameter int NUM_SRC = 32,
  parameter int VEC_W   = 6
) (
  input logic               clk,
  input logic               rst,
  input logic               ack_i,
  input logic               irq_o,
  input logic [VEC_W-1:0]   vec_o,
  input logic [NUM_SRC-1:0] en_q,
  input logic [NUM_SRC-1:0] pend_q,
  input logic               nmi_pend_q
);
  localparam int IDX_W = prio_intc_pkg::idx_width(NUM_SRC);
  localparam logic [VEC_W-1:0] NMI_VEC = VEC_W'(NUM_SRC);

  a_r1_idle_after_reset: assert property (@(posedge clk) rst |=> (!irq_o && vec_o == '0));

  a_r7_vec_range: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (vec_o <= NMI_VEC));

  a_r7_vec_zero_idle: assert property (@(posedge clk) disable iff (rst)
    !irq_o |-> (vec_o == '0));

  a_r8_drop_after_ack: assert property (@(posedge clk) disable iff (rst)
    (ack_i && irq_o) |=> !irq_o);

  a_r3_only_enabled: assert property (@(posedge clk) disable iff (rst)
    (irq_o && vec_o != NMI_VEC) |-> ((($past(en_q) >> vec_o[IDX_W-1:0]) & NUM_SRC'(1)) != '0));

  a_r4_no_higher_winner: assert property (@(posedge clk) disable iff (rst)
    (irq_o && vec_o != NMI_VEC) |-> (((($past(pend_q & en_q)) >> vec_o[IDX_W-1:0]) >> 1) == '0));

  a_r6_nmi_outranks: assert property (@(posedge clk) disable iff (rst)
    (irq_o && vec_o != NMI_VEC) |-> !$past(nmi_pend_q));
endmodule

bind prio_intc prio_intc_checker #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ack_i      (ack_i),
  .irq_o      (irq_o),
  .vec_o      (vec_o),
  .en_q       (en_q),
  .pend_q     (pend_q),
  .nmi_pend_q (nmi_pend_q)
);

// File: tb/prio_intc_tb.sv
module prio_intc_tb;
  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] req = '0;
  logic         en_we = 1'b0;
  logic [N-1:0] en_wdata = '0;
  logic         nmi_n = 1'b1;
  logic         ack = 1'b0;
  logic         irq;
  logic [5:0]   vec;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  prio_intc u_dut (
    .clk        (clk),
    .rst        (rst),
    .irq_req_i  (req),
    .en_we_i    (en_we),
    .en_wdata_i (en_wdata),
    .nmi_n_i    (nmi_n),
    .ack_i      (ack),
    .irq_o      (irq),
    .vec_o      (vec)
  );

  typedef struct packed {
    logic [N-1:0] req;
    logic [N-1:0] en;
    logic         irq;
    logic [5:0]   vec;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t TBL [NV] = '{
    '{32'h0000_0001, 32'hFFFF_FFFF, 1'b1, 6'd0},
    '{32'h8000_0001, 32'hFFFF_FFFF, 1'b1, 6'd31},
    '{32'h0000_00F0, 32'h0000_0030, 1'b1, 6'd5},
    '{32'h0000_00FF, 32'h0000_0000, 1'b0, 6'd0},
    '{32'h0000_0600, 32'hFFFF_FBFF, 1'b1, 6'd9},
    '{32'h0000_0000, 32'hFFFF_FFFF, 1'b0, 6'd0},
    '{32'hFFFF_FFFF, 32'h0000_0001, 1'b1, 6'd0},
    '{32'h0001_0000, 32'h0001_0000, 1'b1, 6'd16}
  };

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic check(input string tag, input logic e_irq, input logic [5:0] e_vec);
    n_chk++;
    if (irq !== e_irq || vec !== e_vec) begin
      n_bad++;
      $display("FAIL %s: actual irq=%0b vec=%0d expected irq=%0b vec=%0d",
               tag, irq, vec, e_irq, e_vec);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; req = '0; en_we = 1'b0; ack = 1'b0; nmi_n = 1'b1;
    tick(1);
    rst = 1'b0;
  endtask

  task automatic set_en(input logic [N-1:0] w);
    en_we = 1'b1; en_wdata = w;
    tick(1);
    en_we = 1'b0;
  endtask

  task automatic pulse_req(input logic [N-1:0] r);
    req = r;
    tick(1);
    req = '0;
  endtask

  task automatic do_ack();
    ack = 1'b1;
    tick(1);
    ack = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(8 * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    #1;
    tick(2);
    check("R1 during reset", 1'b0, 6'd0);
    rst = 1'b0;
    tick(1);
    check("R1 after reset", 1'b0, 6'd0);

    // Vector table: R2, R3, R4
    for (int k = 0; k < NV; k++) begin
      do_reset();
      en_we = 1'b1; en_wdata = TBL[k].en; req = TBL[k].req;
      tick(1);
      en_we = 1'b0; req = '0;
      tick(1);
      check($sformatf("R4 R2 table row %0d", k), TBL[k].irq, TBL[k].vec);
    end

    // R1: reset wipes enable word and pending latches
    do_reset();
    set_en('1);
    pulse_req(32'h0000_0100);
    do_reset();
    tick(2);
    check("R1 pending cleared by reset", 1'b0, 6'd0);
    pulse_req(32'h0000_0002);
    tick(1);
    check("R1 enable cleared by reset", 1'b0, 6'd0);

    // R3: masked pending held, presented on enable
    do_reset();
    pulse_req(32'h0000_0008);
    tick(3);
    check("R3 masked not presented", 1'b0, 6'd0);
    set_en(32'h0000_0008);
    check("R3 enable lag", 1'b0, 6'd0);
    tick(1);
    check("R3 presented after enable", 1'b1, 6'd3);

    // R8: ack clears only presented vector
    do_reset();
    set_en('1);
    pulse_req(32'h0000_0084);
    tick(1);
    check("R8 first winner", 1'b1, 6'd7);
    do_ack();
    check("R8 drop after ack", 1'b0, 6'd0);
    tick(1);
    check("R8 next winner", 1'b1, 6'd2);
    do_ack();
    tick(1);
    check("R8 all cleared", 1'b0, 6'd0);

    // R9: request during its own ack stays pending
    do_reset();
    set_en('1);
    pulse_req(32'h0000_0010);
    tick(1);
    check("R9 presented", 1'b1, 6'd4);
    ack = 1'b1; req = 32'h0000_0010;
    tick(1);
    ack = 1'b0; req = '0;
    check("R9 drop", 1'b0, 6'd0);
    tick(1);
    check("R9 re-presented", 1'b1, 6'd4);

    // R10: ack with no request shown has no effect
    do_reset();
    pulse_req(32'h0000_0040);
    tick(1);
    check("R10 idle before ack", 1'b0, 6'd0);
    do_ack();
    set_en(32'h0000_0040);
    tick(1);
    check("R10 pending survived idle ack", 1'b1, 6'd6);

    // R5 R6: non-maskable over maskable, latency, no retrigger
    do_reset();
    set_en('1);
    pulse_req(32'h8000_0000);
    tick(1);
    check("R5 maskable shown", 1'b1, 6'd31);
    nmi_n = 1'b0;
    tick(3);
    check("R5 before latency", 1'b1, 6'd31);
    tick(1);
    check("R6 nmi outranks", 1'b1, 6'd32);
    do_ack();
    check("R5 drop after nmi ack", 1'b0, 6'd0);
    tick(1);
    check("R5 held low no retrigger", 1'b1, 6'd31);
    do_ack();
    nmi_n = 1'b1;
    tick(6);
    check("R5 rising edge ignored", 1'b0, 6'd0);

    // R6: nmi ignores enable word
    do_reset();
    nmi_n = 1'b0;
    tick(4);
    check("R6 nmi with mask zero", 1'b1, 6'd32);
    do_ack();
    tick(3);
    check("R7 idle vector zero", 1'b0, 6'd0);

    finish_run();
  end
endmodule